// File: doc/BRIEF.md
# Two-Stage Serial Code-Phase Acquisition Detector

This block is the serial-search engine of one correlator unit in a spread-spectrum receiver. It takes a stream of despread in-phase and quadrature chip samples and tests one candidate code phase at a time, inside a window of phases given to this unit. Each candidate first gets a short search dwell. The sum of the squared I and Q correlations is compared against a search threshold. A candidate that passes gets a second, verification dwell with its own length and threshold. Only a pass in both dwells declares acquisition.

When a candidate fails either dwell, the unit steps its phase by one half-chip unit. It pulses a slip output so that the local code source can shift its timing. Then it starts a new search dwell. If the last phase of the window is rejected, the unit raises a window-done flag and stops. Producing the local code is outside this block. The block reports its current phase, and the code source follows it.

Top module: `acq_dwell_detector`

## Requirements
- R1: After a synchronous reset, `busy`, `slip`, `acq_hit` and `win_done` are 0 and `cur_phase` is 0.
- R2: A `start` pulse seen while the unit is not busy captures `win_first`, `win_last`, both dwell lengths and both thresholds. Later changes on those inputs, and `start` pulses while `busy` is 1, do not affect the run in progress.
- R3: In each dwell the unit sums I and Q separately over the chips with `chip_valid` high, and chips with `chip_valid` low are ignored. The metric is (sum I)^2 + (sum Q)^2. The sums clear at the start of every dwell.
- R4: A search dwell lasts `dwell1_len` valid chips. It passes only when the metric is strictly greater than `thr1`, so a metric equal to `thr1` is a miss.
- R5: A search pass is followed by a verification dwell of `dwell2_len` valid chips at the same phase. A metric strictly greater than `thr2` sets `acq_hit`, puts the phase in `acq_phase`, and drops `busy`.
- R6: A miss in either dwell at a phase other than the captured `win_last` adds 1 to `cur_phase`, where one unit is one half chip. The unit raises `slip` for exactly that cycle and starts a new search dwell.
- R7: A run starts at the captured `win_first`, and `cur_phase` never leaves [`win_first`, `win_last`].
- R8: A miss at `win_last` sets `win_done` and drops `busy`. After that the unit stops and `cur_phase` holds until the next accepted `start`.
- R9: With `chip_valid` held high, a dwell of length d takes d cycles, followed by one judging cycle in which chips are ignored. A phase rejected by search therefore costs d1+1 cycles. A phase rejected by verification costs d1+d2+2 cycles.
- R10: `acq_hit` and `win_done` hold until the next accepted `start`, which clears both of them. They are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run and capture the configuration |
| win_first | input | PHASE_W | First phase of the window (half-chip units) |
| win_last | input | PHASE_W | Last phase of the window |
| dwell1_len | input | DWELL_W | Search dwell length in valid chips (nonzero) |
| dwell2_len | input | DWELL_W | Verification dwell length in valid chips (nonzero) |
| thr1 | input | THR_W | Search threshold |
| thr2 | input | THR_W | Verification threshold |
| chip_valid | input | 1 | The chip sample is valid this cycle |
| chip_i | input | SAMP_W | Despread in-phase sample, signed |
| chip_q | input | SAMP_W | Despread quadrature sample, signed |
| busy | output | 1 | A run is in progress |
| cur_phase | output | PHASE_W | Phase under test |
| slip | output | 1 | One-cycle pulse when the phase advances one half chip |
| acq_hit | output | 1 | Acquisition declared |
| acq_phase | output | PHASE_W | Phase at which acquisition was declared |
| win_done | output | 1 | Window exhausted without a hit |

## Verification
The bench sets the threshold exactly equal to the metric at each dwell stage. A design that compared with greater-or-equal would acquire where it should step on. A decoy phase passes search but fails verification. A unit that trusted the first dwell would lock onto the decoy, and one that restarted the window after a verification miss would report the wrong cycle and slip counts. Invalid-chip gaps carry large garbage values, so any leak of ignored chips into the sums, or any sum not cleared between dwells, moves the metric. Changes to the threshold and window inputs, and stray starts in mid-run, show up as a wrong phase or cycle count in a design that does not latch its configuration.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DWELL,
    S_JUDGE,
    S_FOUND,
    S_EMPTY
  } acq_state_e;

  typedef enum logic {
    STG_SEARCH = 1'b0,
    STG_VERIFY = 1'b1
  } acq_stage_e;
endpackage

// File: rtl/iq_dwell_acc.sv
module iq_dwell_acc #(
  parameter int SAMP_W = 8,
  parameter int ACC_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     en,
  input  logic signed [SAMP_W-1:0] in_i,
  input  logic signed [SAMP_W-1:0] in_q,
  output logic signed [ACC_W-1:0]  sum_i,
  output logic signed [ACC_W-1:0]  sum_q
);
  localparam int LANES = 2;
  localparam int EXT_W = ACC_W - SAMP_W;

  logic signed [SAMP_W-1:0] lane_in  [LANES];
  logic signed [ACC_W-1:0]  lane_sum [LANES];

  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        lane_sum[g] <= '0;
      end else if (en) begin
        lane_sum[g] <= lane_sum[g] + {{EXT_W{lane_in[g][SAMP_W-1]}}, lane_in[g]};
      end
    end

    // R3: an idle cycle leaves the running sum untouched
    a_r3_sum_holds: assert property (@(posedge clk) disable iff (rst)
      (!en && !clr) |=> $stable(lane_sum[g]));
  end

  assign sum_i = lane_sum[0];
  assign sum_q = lane_sum[1];
endmodule

// File: rtl/energy_judge.sv
module energy_judge #(
  parameter int ACC_W = 16,
  parameter int THR_W = 33
) (
  input  logic signed [ACC_W-1:0] sum_i,
  input  logic signed [ACC_W-1:0] sum_q,
  input  logic        [THR_W-1:0] thr,
  output logic                    pass
);
  localparam int SQ_W = 2 * ACC_W;

  logic signed [SQ_W-1:0] sq_i;
  logic signed [SQ_W-1:0] sq_q;
  logic        [SQ_W:0]   energy;

  always_comb begin
    sq_i   = SQ_W'(sum_i) * SQ_W'(sum_i);
    sq_q   = SQ_W'(sum_q) * SQ_W'(sum_q);
    energy = {1'b0, sq_i} + {1'b0, sq_q};
    pass   = THR_W'(energy) > thr;
  end
endmodule

// File: rtl/phase_walker.sv
module phase_walker #(
  parameter int PHASE_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [PHASE_W-1:0] first,
  input  logic [PHASE_W-1:0] last,
  input  logic               advance,
  output logic [PHASE_W-1:0] phase,
  output logic               at_last,
  output logic               slip
);
  logic [PHASE_W-1:0] lo_q;
  logic [PHASE_W-1:0] hi_q;

  assign at_last = (phase == hi_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      slip  <= 1'b0;
    end else begin
      slip <= 1'b0;
      if (load) begin
        phase <= first;
        lo_q  <= first;
        hi_q  <= last;
      end else if (advance && !at_last) begin
        phase <= phase + PHASE_W'(1);
        slip  <= 1'b1;
      end
    end
  end

  // R6: every slip pulse marks a single half-chip step
  a_r6_slip_step: assert property (@(posedge clk) disable iff (rst)
    slip |-> (phase == PHASE_W'($past(phase) + PHASE_W'(1))));

  // R7: the phase stays inside the captured window
  a_r7_phase_in_window: assert property (@(posedge clk) disable iff (rst)
    (phase >= lo_q) && (phase <= hi_q));
endmodule

// File: rtl/acq_dwell_detector.sv
module acq_dwell_detector #(
  parameter int SAMP_W  = 8,
  parameter int DWELL_W = 8,
  parameter int PHASE_W = 12,
  parameter int THR_W   = 2 * (SAMP_W + DWELL_W) + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [PHASE_W-1:0]        win_first,
  input  logic [PHASE_W-1:0]        win_last,
  input  logic [DWELL_W-1:0]        dwell1_len,
  input  logic [DWELL_W-1:0]        dwell2_len,
  input  logic [THR_W-1:0]          thr1,
  input  logic [THR_W-1:0]          thr2,
  input  logic                      chip_valid,
  input  logic signed [SAMP_W-1:0]  chip_i,
  input  logic signed [SAMP_W-1:0]  chip_q,
  output logic                      busy,
  output logic [PHASE_W-1:0]        cur_phase,
  output logic                      slip,
  output logic                      acq_hit,
  output logic [PHASE_W-1:0]        acq_phase,
  output logic                      win_done
);
  import acq_pkg::*;

  localparam int ACC_W = SAMP_W + DWELL_W;

  acq_state_e          state;
  acq_stage_e          stage;
  logic [DWELL_W-1:0]  cnt;
  logic [DWELL_W-1:0]  len1_q, len2_q, cur_len;
  logic [THR_W-1:0]    thr1_q, thr2_q, cur_thr;
  logic                start_ok;
  logic                acc_clr, acc_en;
  logic                judge_pass;
  logic                advance;
  logic                at_last;
  logic signed [ACC_W-1:0] sum_i, sum_q;

  assign start_ok = start && (state != S_DWELL) && (state != S_JUDGE);
  assign cur_len  = (stage == STG_VERIFY) ? len2_q : len1_q;
  assign cur_thr  = (stage == STG_VERIFY) ? thr2_q : thr1_q;
  assign acc_clr  = start_ok || (state == S_JUDGE);
  assign acc_en   = (state == S_DWELL) && chip_valid;
  assign advance  = (state == S_JUDGE) && !judge_pass;

  iq_dwell_acc #(.SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .clr   (acc_clr),
    .en    (acc_en),
    .in_i  (chip_i),
    .in_q  (chip_q),
    .sum_i (sum_i),
    .sum_q (sum_q)
  );

  energy_judge #(.ACC_W(ACC_W), .THR_W(THR_W)) u_judge (
    .sum_i (sum_i),
    .sum_q (sum_q),
    .thr   (cur_thr),
    .pass  (judge_pass)
  );

  phase_walker #(.PHASE_W(PHASE_W)) u_walk (
    .clk     (clk),
    .rst     (rst),
    .load    (start_ok),
    .first   (win_first),
    .last    (win_last),
    .advance (advance),
    .phase   (cur_phase),
    .at_last (at_last),
    .slip    (slip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      stage     <= STG_SEARCH;
      cnt       <= '0;
      len1_q    <= '0;
      len2_q    <= '0;
      thr1_q    <= '0;
      thr2_q    <= '0;
      busy      <= 1'b0;
      acq_hit   <= 1'b0;
      acq_phase <= '0;
      win_done  <= 1'b0;
    end else begin
      case (state)
        S_DWELL: begin
          if (chip_valid) begin
            if (cnt == cur_len - DWELL_W'(1)) begin
              cnt   <= '0;
              state <= S_JUDGE;
            end else begin
              cnt <= cnt + DWELL_W'(1);
            end
          end
        end
        S_JUDGE: begin
          if (judge_pass && stage == STG_SEARCH) begin
            stage <= STG_VERIFY;
            state <= S_DWELL;
          end else if (judge_pass) begin
            state     <= S_FOUND;
            acq_hit   <= 1'b1;
            acq_phase <= cur_phase;
            busy      <= 1'b0;
          end else if (at_last) begin
            state    <= S_EMPTY;
            win_done <= 1'b1;
            busy     <= 1'b0;
          end else begin
            stage <= STG_SEARCH;
            state <= S_DWELL;
          end
        end
        default: begin
          if (start_ok) begin
            state    <= S_DWELL;
            stage    <= STG_SEARCH;
            cnt      <= '0;
            len1_q   <= dwell1_len;
            len2_q   <= dwell2_len;
            thr1_q   <= thr1;
            thr2_q   <= thr2;
            busy     <= 1'b1;
            acq_hit  <= 1'b0;
            win_done <= 1'b0;
          end
        end
      endcase
    end
  end

  // R5: a hit only follows the judging of a verification dwell
  a_r5_hit_after_verify: assert property (@(posedge clk) disable iff (rst)
    $rose(acq_hit) |-> ($past(state) == S_JUDGE && $past(stage) == STG_VERIFY));

  // R8: once finished, the phase does not move until a new start
  a_r8_stop_hold: assert property (@(posedge clk) disable iff (rst)
    ((win_done || acq_hit) && !start) |=> $stable(cur_phase));

  // R9: the dwell counter stays below the active dwell length
  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    (state == S_DWELL) |-> (cnt < cur_len));

  // R10: hit and exhausted are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(acq_hit && win_done));
endmodule

// File: tb/test_acq_dwell_detector.sv
module test_acq_dwell_detector;
  localparam int SW = 8;
  localparam int DW = 8;
  localparam int PW = 12;
  localparam int TW = 2 * (SW + DW) + 1;
  localparam int NV = 11;
  localparam int NONE = 4095;

  typedef struct packed {
    logic [PW-1:0]        first;
    logic [PW-1:0]        last;
    logic [DW-1:0]        d1;
    logic [DW-1:0]        d2;
    logic [TW-1:0]        t1;
    logic [TW-1:0]        t2;
    logic [PW-1:0]        tgt;
    logic [PW-1:0]        dec;
    logic signed [SW-1:0] sa;
    logic signed [SW-1:0] sm;
    logic                 gap;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{12'd10, 12'd20, 8'd8, 8'd16, 33'd1000, 33'd100000, 12'd14, 12'd4095, 8'sd20, 8'sd0, 1'b0},
    '{12'd10, 12'd20, 8'd8, 8'd16, 33'd1000, 33'd100000, 12'd14, 12'd12, 8'sd20, 8'sd10, 1'b0},
    '{12'd10, 12'd20, 8'd8, 8'd16, 33'd1000, 33'd100000, 12'd30, 12'd4095, 8'sd20, 8'sd0, 1'b0},
    '{12'd5, 12'd7, 8'd4, 8'd4, 33'd3200, 33'd3199, 12'd5, 12'd4095, 8'sd10, 8'sd0, 1'b0},
    '{12'd5, 12'd7, 8'd4, 8'd4, 33'd3199, 33'd3199, 12'd5, 12'd4095, 8'sd10, 8'sd0, 1'b0},
    '{12'd5, 12'd7, 8'd4, 8'd4, 33'd3199, 33'd3200, 12'd5, 12'd4095, 8'sd10, 8'sd0, 1'b0},
    '{12'd7, 12'd7, 8'd6, 8'd6, 33'd500, 33'd500, 12'd7, 12'd4095, 8'sd12, 8'sd0, 1'b0},
    '{12'd10, 12'd20, 8'd8, 8'd16, 33'd1000, 33'd100000, 12'd14, 12'd4095, 8'sd20, 8'sd0, 1'b1},
    '{12'd10, 12'd20, 8'd8, 8'd16, 33'd1000, 33'd100000, 12'd20, 12'd4095, 8'sd20, 8'sd0, 1'b0},
    '{12'd0, 12'd15, 8'd10, 8'd10, 33'd5000, 33'd5000, 12'd0, 12'd4095, -8'sd30, 8'sd0, 1'b0},
    '{12'd100, 12'd131, 8'd5, 8'd9, 33'd300, 33'd2000, 12'd129, 12'd110, -8'sd20, -8'sd3, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [PW-1:0] win_first = '0, win_last = '0;
  logic [DW-1:0] dwell1_len = 8'd1, dwell2_len = 8'd1;
  logic [TW-1:0] thr1 = '0, thr2 = '0;
  logic chip_valid = 1'b0;
  logic signed [SW-1:0] chip_i = '0, chip_q = '0;
  logic busy, slip, acq_hit, win_done;
  logic [PW-1:0] cur_phase, acq_phase;

  int checks = 0;
  int failures = 0;
  int busy_cyc = 0;
  int slip_cnt = 0;
  int gap_ctr = 0;
  vec_t cfg;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  acq_dwell_detector #(.SAMP_W(SW), .DWELL_W(DW), .PHASE_W(PW)) i_acq_dwell_detector (
    .clk(clk), .rst(rst), .start(start),
    .win_first(win_first), .win_last(win_last),
    .dwell1_len(dwell1_len), .dwell2_len(dwell2_len),
    .thr1(thr1), .thr2(thr2),
    .chip_valid(chip_valid), .chip_i(chip_i), .chip_q(chip_q),
    .busy(busy), .cur_phase(cur_phase), .slip(slip),
    .acq_hit(acq_hit), .acq_phase(acq_phase), .win_done(win_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void amps(input vec_t v, input int p, output int a, output int b);
    if (p == int'(v.tgt)) begin a = int'(v.sa); b = -int'(v.sa); end
    else if (p == int'(v.dec)) begin a = int'(v.sm); b = -int'(v.sm); end
    else begin a = 1; b = 1; end
  endfunction

  function automatic longint energy(input int d, input int a, input int b);
    longint x = longint'(d) * a;
    longint y = longint'(d) * b;
    return x * x + y * y;
  endfunction

  task automatic model(input vec_t v, output bit hit, output int ph,
                       output int cyc, output int slips);
    int a, b;
    hit = 0; ph = 0; cyc = 0; slips = 0;
    for (int p = int'(v.first); p <= int'(v.last); p++) begin
      amps(v, p, a, b);
      cyc += int'(v.d1) + 1;
      if (energy(int'(v.d1), a, b) > longint'(v.t1)) begin
        cyc += int'(v.d2) + 1;
        if (energy(int'(v.d2), a, b) > longint'(v.t2)) begin
          hit = 1; ph = p;
          return;
        end
      end
      if (p != int'(v.last)) slips++;
    end
  endtask

  task automatic chip_driver();
    int a, b;
    forever begin
      @(negedge clk);
      if (busy) busy_cyc++;
      if (slip) slip_cnt++;
      gap_ctr++;
      if (cfg.gap && (gap_ctr % 3 == 2)) begin
        chip_valid = 1'b0; chip_i = 8'sd100; chip_q = 8'sd100;
      end else begin
        amps(cfg, int'(cur_phase), a, b);
        chip_valid = 1'b1; chip_i = SW'(a); chip_q = SW'(b);
      end
    end
  endtask

  task automatic apply_cfg(input vec_t v);
    cfg = v;
    win_first = v.first; win_last = v.last;
    dwell1_len = v.d1; dwell2_len = v.d2;
    thr1 = v.t1; thr2 = v.t2;
  endtask

  task automatic run(input vec_t v, input bit perturb, input string tag);
    bit e_hit; int e_ph, e_cyc, e_slip, guard;
    model(v, e_hit, e_ph, e_cyc, e_slip);
    apply_cfg(v);
    @(negedge clk); #1;
    start = 1'b1; busy_cyc = 0; slip_cnt = 0;
    @(negedge clk); #1;
    start = 1'b0;
    guard = 0;
    while (busy && guard < 5000) begin
      if (perturb && guard == 5) begin
        thr1 = '0; thr2 = '0; win_first = '0; win_last = 12'd4000;
        dwell1_len = 8'd1; dwell2_len = 8'd1; start = 1'b1;
      end else if (perturb && guard == 6) begin
        start = 1'b0;
      end
      @(negedge clk); #1;
      guard++;
    end
    chk(guard < 5000, "R8", {tag, " run ends"}, guard, 0);
    chk(acq_hit == e_hit, tag, "hit flag", acq_hit, e_hit);
    chk(win_done == !e_hit, "R8", "window done flag", win_done, !e_hit);
    chk(!(acq_hit && win_done), "R10", "exclusive flags", acq_hit + win_done, 1);
    if (e_hit) chk(acq_phase == PW'(e_ph), "R7", "hit phase", acq_phase, e_ph);
    chk(slip_cnt == e_slip, "R6", "slip count", slip_cnt, e_slip);
    if (!v.gap) chk(busy_cyc == e_cyc, "R9", "busy cycles", busy_cyc, e_cyc);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cfg = VECS[0];
    fork chip_driver(); join_none
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk(!busy && !slip && !acq_hit && !win_done, "R1", "flags after reset",
        {busy, slip, acq_hit, win_done}, 0);
    chk(cur_phase == '0, "R1", "phase after reset", cur_phase, 0);
    rst = 1'b0;
    @(negedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = (i == 7 || i == 10) ? "R3" : (i == 3) ? "R4" : "R5";
      run(VECS[i], 1'b0, tg);
    end

    // R2: config inputs changed and start re-pulsed mid-run
    run(VECS[1], 1'b1, "R2");

    // R8: after exhaustion the unit stays stopped
    run(VECS[2], 1'b0, "R8");
    slip_cnt = 0;
    busy_cyc = 0;
    repeat (20) @(negedge clk);
    #1;
    chk(cur_phase == 12'd20, "R8", "phase holds", cur_phase, 20);
    chk(busy_cyc == 0 && slip_cnt == 0, "R8", "no activity", busy_cyc + slip_cnt, 0);
    chk(win_done && !acq_hit, "R10", "done held", win_done, 1);

    // R10: restart clears done, then reports a hit
    run(VECS[0], 1'b0, "R10");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule